// File: doc/BRIEF.md
# Word-Packed Serial Receiver with Idle Timeout

This block is the receive half of an asynchronous serial port. It recovers 8-N-1 characters from an oversampled line and packs them into 32-bit words, four characters per word. Full words go into a small receive FIFO. Software reads the FIFO through a show-ahead read port. The byte that arrived first sits in the lowest byte lane of its word.

A burst ends when the line has been idle for a programmable number of character times. At that point the block pushes any partly filled word into the FIFO, zero-filling its unused upper lanes. It also raises a stale interrupt flag and latches the number of characters in the burst into a snapshot count. From the snapshot and the number of words read, software can work out how many bytes of the last word are valid.

Control uses a one-cycle command strobe with an opcode. Status comes back on level outputs for overrun, framing error, receiver enable and stale arming. The oversampling tick comes from a separate baud generator.

Top module: `wpk_uart_rx`

## Requirements
- R1: A character is a low start bit, 8 data bits sent LSB first, and a high stop bit. Each bit lasts OSR (default 16) cycles in which `os_tick` is high. A start bit that is no longer low at its midpoint is discarded.
- R2: Byte lanes of a word fill in arrival order. The first character of a word goes to bits 7:0, the second to 15:8, the third to 23:16 and the fourth to 31:24.
- R3: The word is pushed into the FIFO when its fourth character is accepted. `rd_data` always shows the oldest entry. A one-cycle `rd_en` while `rx_empty` is low removes that entry, and `rx_level` never exceeds the FIFO depth.
- R4: The stale event fires when the burst has at least one character, stale is armed, and the line has stayed idle for `stale_limit` character times (10*OSR ticks each; a limit of 0 acts as 1). The event pushes a partial word with its unused lanes set to zero and sets `stale_irq`.
- R5: On the stale event, `snap_count` takes the number of characters accepted in the burst. The valid bytes of the last word equal 4 - (4*words_read - snap_count).
- R6: Every start bit restarts the idle timer, so an idle gap shorter than the limit does not end the burst.
- R7: Commands use `cmd_op` codes 0 none, 1 receiver reset, 2 receiver enable, 3 stale clear, 4 stale arm, 5 error clear, 6 receiver disable. The stale event disarms stale, and no further event occurs until opcode 4. Opcode 3 clears `stale_irq`.
- R8: A character that completes while the FIFO is full is dropped and sets `ovr_err`. `ovr_err` stays set until opcode 5.
- R9: A frame whose stop bit samples low is dropped and sets `frm_err`, which clears only on opcode 5. The receiver then waits for the line to return high before it looks for a new start bit.
- R10: Opcode 1 empties the FIFO, clears the partial word, the burst count and `snap_count`, and disables the receiver. It does not clear `ovr_err`.
- R11: While `rx_on` is low, line activity produces no characters.
- R12: After reset the FIFO is empty, `snap_count` is 0, and `rx_on`, `stale_irq`, `stale_armed`, `ovr_err` and `frm_err` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| os_tick | input | 1 | Oversampling tick, OSR per bit |
| rxd | input | 1 | Serial line, idle high |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 3 | Command opcode |
| stale_limit | input | STALE_W | Idle timeout in character times |
| rd_en | input | 1 | Pop the oldest FIFO word |
| rd_data | output | LANES*DBITS | Oldest FIFO word |
| rx_empty | output | 1 | FIFO empty |
| rx_level | output | clog2(DEPTH+1) | FIFO occupancy |
| rx_on | output | 1 | Receiver enabled |
| stale_irq | output | 1 | Stale event flag |
| stale_armed | output | 1 | Stale event armed |
| ovr_err | output | 1 | Overrun status |
| frm_err | output | 1 | Framing error status |
| snap_count | output | CNT_W | Characters in the last finished burst |

## Verification
A wrong lane index or a stray packing value appears at `rd_data` as soon as the burst's first word is read. A stuck or mis-sized idle timer shows either as a `stale_irq` that never rises or as one that rises before a second character that should have extended the burst. A burst counter that is off by one shows in `snap_count` and in the valid-byte arithmetic at the end of every burst. State left behind by a receiver reset shows up as stale bytes inside the first word of the following burst.

// File: rtl/wpk_pkg.sv
package wpk_pkg;

   typedef enum logic [2:0] {
      CMD_NONE       = 3'd0,
      CMD_RX_RESET   = 3'd1,
      CMD_RX_ENABLE  = 3'd2,
      CMD_STALE_CLR  = 3'd3,
      CMD_STALE_ARM  = 3'd4,
      CMD_ERR_CLR    = 3'd5,
      CMD_RX_DISABLE = 3'd6
   } wpk_cmd_e;

   typedef enum logic [2:0] {
      DS_IDLE,
      DS_START,
      DS_DATA,
      DS_STOP,
      DS_HOLD
   } wpk_ds_e;

endpackage

// File: rtl/wpk_deser.sv
module wpk_deser #(
   parameter int OSR   = 16,
   parameter int DBITS = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic             tick,
   input  logic             rxd,
   output logic             start_o,
   output logic             busy_o,
   output logic             chr_vld_o,
   output logic             ferr_o,
   output logic [DBITS-1:0] chr_o
);
   import wpk_pkg::*;

   localparam int CW = $clog2(OSR);
   localparam int BW = $clog2(DBITS);
   localparam logic [CW-1:0] MID   = CW'(OSR / 2 - 1);
   localparam logic [CW-1:0] LAST  = CW'(OSR - 1);
   localparam logic [BW-1:0] BLAST = BW'(DBITS - 1);

   generate
      if (OSR < 4) begin : g_bad_osr
         $error("wpk_deser: OSR must be at least 4");
      end
      if (DBITS < 5 || DBITS > 9) begin : g_bad_dbits
         $error("wpk_deser: DBITS must be 5 to 9");
      end
   endgenerate

   logic [1:0]       sync_q;
   logic             rxs;
   wpk_ds_e          state_q;
   logic [CW-1:0]    cnt_q;
   logic [BW-1:0]    bidx_q;
   logic [DBITS-1:0] shreg_q;
   logic             at_last;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sync_q <= 2'b11;
      else        sync_q <= {sync_q[0], rxd};
   end

   assign rxs     = sync_q[1];
   assign at_last = tick && (cnt_q == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= DS_IDLE;
         cnt_q   <= '0;
         bidx_q  <= '0;
         shreg_q <= '0;
      end else if (!en) begin
         state_q <= DS_IDLE;
         cnt_q   <= '0;
         bidx_q  <= '0;
      end else if (tick) begin
         case (state_q)
            DS_IDLE: begin
               if (!rxs) begin
                  state_q <= DS_START;
                  cnt_q   <= '0;
               end
            end
            DS_START: begin
               if (cnt_q == MID) begin
                  cnt_q   <= '0;
                  bidx_q  <= '0;
                  state_q <= rxs ? DS_IDLE : DS_DATA;
               end else begin
                  cnt_q <= cnt_q + 1'b1;
               end
            end
            DS_DATA: begin
               if (cnt_q == LAST) begin
                  cnt_q   <= '0;
                  shreg_q <= {rxs, shreg_q[DBITS-1:1]};
                  if (bidx_q == BLAST) state_q <= DS_STOP;
                  else                 bidx_q  <= bidx_q + 1'b1;
               end else begin
                  cnt_q <= cnt_q + 1'b1;
               end
            end
            DS_STOP: begin
               if (cnt_q == LAST) begin
                  cnt_q   <= '0;
                  state_q <= rxs ? DS_IDLE : DS_HOLD;
               end else begin
                  cnt_q <= cnt_q + 1'b1;
               end
            end
            DS_HOLD: begin
               if (rxs) state_q <= DS_IDLE;
            end
            default: state_q <= DS_IDLE;
         endcase
      end
   end

   assign start_o   = en && tick && (state_q == DS_IDLE) && !rxs;
   assign chr_vld_o = en && (state_q == DS_STOP) && at_last && rxs;
   assign ferr_o    = en && (state_q == DS_STOP) && at_last && !rxs;
   assign busy_o    = (state_q != DS_IDLE);
   assign chr_o     = shreg_q;

endmodule

// File: rtl/wpk_pack.sv
module wpk_pack #(
   parameter int OSR     = 16,
   parameter int DBITS   = 8,
   parameter int LANES   = 4,
   parameter int STALE_W = 8,
   parameter int CNT_W   = 16
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   clr,
   input  logic                   tick,
   input  logic                   start_i,
   input  logic                   busy_i,
   input  logic                   chr_vld_i,
   input  logic [DBITS-1:0]       chr_i,
   input  logic                   stale_en_i,
   input  logic [STALE_W-1:0]     stale_lim_i,
   input  logic                   fifo_full_i,
   output logic                   push_o,
   output logic [LANES*DBITS-1:0] push_data_o,
   output logic                   ovr_o,
   output logic                   stale_o,
   output logic [CNT_W-1:0]       snap_o
);
   localparam int WW         = LANES * DBITS;
   localparam int LW         = $clog2(LANES);
   localparam int CHAR_TICKS = OSR * (DBITS + 2);
   localparam int TW         = $clog2(CHAR_TICKS);
   localparam logic [LW-1:0] LANE_LAST = LW'(LANES - 1);
   localparam logic [TW-1:0] TICK_LAST = TW'(CHAR_TICKS - 1);

   generate
      if (LANES < 2 || (LANES & (LANES - 1)) != 0) begin : g_bad_lanes
         $error("wpk_pack: LANES must be a power of two, at least 2");
      end
      if (CNT_W < 2) begin : g_bad_cnt
         $error("wpk_pack: CNT_W too small");
      end
   endgenerate

   logic [WW-1:0]      word_q, nxt_word;
   logic [LW-1:0]      lane_q;
   logic [CNT_W-1:0]   burst_q, snap_q;
   logic [TW-1:0]      tcnt_q;
   logic [STALE_W-1:0] ccnt_q, lim_eff;
   logic               accept, full_word, expired, fire, timer_run;

   assign accept    = chr_vld_i && !fifo_full_i && !clr;
   assign ovr_o     = chr_vld_i && fifo_full_i;
   assign full_word = accept && (lane_q == LANE_LAST);
   assign lim_eff   = (stale_lim_i == '0) ? STALE_W'(1) : stale_lim_i;
   assign expired   = (ccnt_q >= lim_eff);
   assign fire      = stale_en_i && (burst_q != '0) && expired && !busy_i &&
                      !start_i && !clr && (!fifo_full_i || lane_q == '0);
   assign timer_run = tick && stale_en_i && (burst_q != '0) && !busy_i && !expired;

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      assign nxt_word[g*DBITS +: DBITS] = (accept && lane_q == LW'(g)) ?
                                          chr_i : word_q[g*DBITS +: DBITS];
   end

   assign push_o      = full_word || (fire && lane_q != '0);
   assign push_data_o = nxt_word;
   assign stale_o     = fire;
   assign snap_o      = snap_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         word_q  <= '0;
         lane_q  <= '0;
         burst_q <= '0;
         snap_q  <= '0;
         tcnt_q  <= '0;
         ccnt_q  <= '0;
      end else if (clr) begin
         word_q  <= '0;
         lane_q  <= '0;
         burst_q <= '0;
         snap_q  <= '0;
         tcnt_q  <= '0;
         ccnt_q  <= '0;
      end else begin
         if (accept) begin
            word_q <= full_word ? '0 : nxt_word;
            lane_q <= lane_q + 1'b1;
            if (burst_q != '1) burst_q <= burst_q + 1'b1;
         end
         if (fire) begin
            word_q  <= '0;
            lane_q  <= '0;
            burst_q <= '0;
            snap_q  <= burst_q;
         end
         if (start_i || fire) begin
            tcnt_q <= '0;
            ccnt_q <= '0;
         end else if (timer_run) begin
            if (tcnt_q == TICK_LAST) begin
               tcnt_q <= '0;
               ccnt_q <= ccnt_q + 1'b1;
            end else begin
               tcnt_q <= tcnt_q + 1'b1;
            end
         end
      end
   end

endmodule

// File: rtl/wpk_fifo.sv
module wpk_fifo #(
   parameter int WIDTH = 32,
   parameter int DEPTH = 4
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       clr,
   input  logic                       push,
   input  logic [WIDTH-1:0]           din,
   input  logic                       pop,
   output logic [WIDTH-1:0]           dout,
   output logic                       empty,
   output logic                       full,
   output logic [$clog2(DEPTH+1)-1:0] level
);
   localparam int AW = $clog2(DEPTH);
   localparam int LV = $clog2(DEPTH + 1);

   generate
      if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
         $error("wpk_fifo: DEPTH must be a power of two, at least 2");
      end
   endgenerate

   logic [WIDTH-1:0] mem_q [DEPTH];
   logic [AW-1:0]    wptr_q, rptr_q;
   logic [LV-1:0]    cnt_q;
   logic             do_push, do_pop;

   assign empty   = (cnt_q == '0);
   assign full    = (cnt_q == LV'(DEPTH));
   assign level   = cnt_q;
   assign dout    = mem_q[rptr_q];
   assign do_push = push && !full;
   assign do_pop  = pop && !empty;

   always_ff @(posedge clk) begin
      if (do_push && !clr) mem_q[wptr_q] <= din;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wptr_q <= '0;
         rptr_q <= '0;
         cnt_q  <= '0;
      end else if (clr) begin
         wptr_q <= '0;
         rptr_q <= '0;
         cnt_q  <= '0;
      end else begin
         if (do_push) wptr_q <= wptr_q + 1'b1;
         if (do_pop)  rptr_q <= rptr_q + 1'b1;
         case ({do_push, do_pop})
            2'b10:   cnt_q <= cnt_q + 1'b1;
            2'b01:   cnt_q <= cnt_q - 1'b1;
            default: cnt_q <= cnt_q;
         endcase
      end
   end

endmodule

// File: rtl/wpk_uart_rx.sv
module wpk_uart_rx #(
   parameter int OSR     = 16,
   parameter int DBITS   = 8,
   parameter int LANES   = 4,
   parameter int DEPTH   = 4,
   parameter int STALE_W = 8,
   parameter int CNT_W   = 16,
   localparam int WW     = LANES * DBITS,
   localparam int LVL_W  = $clog2(DEPTH + 1)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               os_tick,
   input  logic               rxd,
   input  logic               cmd_valid,
   input  logic [2:0]         cmd_op,
   input  logic [STALE_W-1:0] stale_limit,
   input  logic               rd_en,
   output logic [WW-1:0]      rd_data,
   output logic               rx_empty,
   output logic [LVL_W-1:0]   rx_level,
   output logic               rx_on,
   output logic               stale_irq,
   output logic               stale_armed,
   output logic               ovr_err,
   output logic               frm_err,
   output logic [CNT_W-1:0]   snap_count
);
   import wpk_pkg::*;

   logic             c_reset, c_enable, c_disable, c_sclr, c_sarm, c_eclr;
   logic             rx_on_q, irq_q, arm_q, ovr_q, ferr_q;
   logic             ds_start, ds_busy, ds_vld, ds_ferr;
   logic [DBITS-1:0] ds_chr;
   logic             pk_push, pk_ovr, pk_stale;
   logic [WW-1:0]    pk_data;
   logic             ff_full;

   assign c_reset   = cmd_valid && (cmd_op == CMD_RX_RESET);
   assign c_enable  = cmd_valid && (cmd_op == CMD_RX_ENABLE);
   assign c_disable = cmd_valid && (cmd_op == CMD_RX_DISABLE);
   assign c_sclr    = cmd_valid && (cmd_op == CMD_STALE_CLR);
   assign c_sarm    = cmd_valid && (cmd_op == CMD_STALE_ARM);
   assign c_eclr    = cmd_valid && (cmd_op == CMD_ERR_CLR);

   wpk_deser #(.OSR(OSR), .DBITS(DBITS)) i_deser (
      .clk      (clk),
      .rst_n    (rst_n),
      .en       (rx_on_q),
      .tick     (os_tick),
      .rxd      (rxd),
      .start_o  (ds_start),
      .busy_o   (ds_busy),
      .chr_vld_o(ds_vld),
      .ferr_o   (ds_ferr),
      .chr_o    (ds_chr)
   );

   wpk_pack #(
      .OSR(OSR), .DBITS(DBITS), .LANES(LANES), .STALE_W(STALE_W), .CNT_W(CNT_W)
   ) i_pack (
      .clk        (clk),
      .rst_n      (rst_n),
      .clr        (c_reset),
      .tick       (os_tick),
      .start_i    (ds_start),
      .busy_i     (ds_busy),
      .chr_vld_i  (ds_vld),
      .chr_i      (ds_chr),
      .stale_en_i (arm_q),
      .stale_lim_i(stale_limit),
      .fifo_full_i(ff_full),
      .push_o     (pk_push),
      .push_data_o(pk_data),
      .ovr_o      (pk_ovr),
      .stale_o    (pk_stale),
      .snap_o     (snap_count)
   );

   wpk_fifo #(.WIDTH(WW), .DEPTH(DEPTH)) i_fifo (
      .clk  (clk),
      .rst_n(rst_n),
      .clr  (c_reset),
      .push (pk_push),
      .din  (pk_data),
      .pop  (rd_en),
      .dout (rd_data),
      .empty(rx_empty),
      .full (ff_full),
      .level(rx_level)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rx_on_q <= 1'b0;
         irq_q   <= 1'b0;
         arm_q   <= 1'b0;
         ovr_q   <= 1'b0;
         ferr_q  <= 1'b0;
      end else begin
         if (c_reset || c_disable) rx_on_q <= 1'b0;
         else if (c_enable)        rx_on_q <= 1'b1;

         if (pk_stale)    irq_q <= 1'b1;
         else if (c_sclr) irq_q <= 1'b0;

         if (pk_stale)    arm_q <= 1'b0;
         else if (c_sarm) arm_q <= 1'b1;

         if (pk_ovr)      ovr_q <= 1'b1;
         else if (c_eclr) ovr_q <= 1'b0;

         if (ds_ferr)     ferr_q <= 1'b1;
         else if (c_eclr) ferr_q <= 1'b0;
      end
   end

   assign rx_on       = rx_on_q;
   assign stale_irq   = irq_q;
   assign stale_armed = arm_q;
   assign ovr_err     = ovr_q;
   assign frm_err     = ferr_q;

endmodule

// File: rtl/wpk_uart_rx_chk.sv
module wpk_uart_rx_chk #(
   parameter int DEPTH = 4,
   parameter int CNT_W = 16,
   parameter int LVL_W = 3
) (
   input logic             clk,
   input logic             rst_n,
   input logic             cmd_valid,
   input logic [2:0]       cmd_op,
   input logic             push,
   input logic             fifo_full,
   input logic             rx_empty,
   input logic [LVL_W-1:0] rx_level,
   input logic             ovr_err,
   input logic             frm_err,
   input logic             stale_irq,
   input logic             stale_armed,
   input logic             stale_pulse,
   input logic [CNT_W-1:0] snap_count
);
   import wpk_pkg::*;

   logic is_eclr, is_reset, is_arm;
   assign is_eclr  = cmd_valid && (cmd_op == CMD_ERR_CLR);
   assign is_reset = cmd_valid && (cmd_op == CMD_RX_RESET);
   assign is_arm   = cmd_valid && (cmd_op == CMD_STALE_ARM);

   AST_NO_PUSH_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
      push |-> !fifo_full);  // R8
   AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      rx_level <= LVL_W'(DEPTH));  // R3
   AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      ovr_err && !is_eclr |=> ovr_err);  // R8
   AST_FERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      frm_err && !is_eclr |=> frm_err);  // R9
   AST_RESET_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
      is_reset |=> rx_empty && snap_count == '0);  // R10
   AST_STALE_NEEDS_ARM: assert property (@(posedge clk) disable iff (!rst_n)
      stale_pulse |-> stale_armed);  // R7
   AST_STALE_DISARMS: assert property (@(posedge clk) disable iff (!rst_n)
      stale_pulse |=> !stale_armed);  // R7
   AST_STALE_SETS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
      stale_pulse |=> stale_irq);  // R4

endmodule

bind wpk_uart_rx wpk_uart_rx_chk #(
   .DEPTH(DEPTH), .CNT_W(CNT_W), .LVL_W(LVL_W)
) i_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .cmd_valid  (cmd_valid),
   .cmd_op     (cmd_op),
   .push       (pk_push),
   .fifo_full  (ff_full),
   .rx_empty   (rx_empty),
   .rx_level   (rx_level),
   .ovr_err    (ovr_err),
   .frm_err    (frm_err),
   .stale_irq  (stale_irq),
   .stale_armed(stale_armed),
   .stale_pulse(pk_stale),
   .snap_count (snap_count)
);

// File: tb/test_wpk_uart_rx.sv
module test_wpk_uart_rx;
   localparam int OSR = 16;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        os_tick = 1'b1;
   logic        rxd = 1'b1;
   logic        cmd_valid = 1'b0;
   logic [2:0]  cmd_op = 3'd0;
   logic [7:0]  stale_limit = 8'd2;
   logic        rd_en = 1'b0;
   logic [31:0] rd_data;
   logic        rx_empty;
   logic [2:0]  rx_level;
   logic        rx_on, stale_irq, stale_armed, ovr_err, frm_err;
   logic [15:0] snap_count;

   int n_tests = 0;
   int n_fail  = 0;
   logic [7:0] sent [0:31];
   int nsent;

   always #4 clk = ~clk;

   wpk_uart_rx i_wpk_uart_rx (
      .clk(clk), .rst_n(rst_n), .os_tick(os_tick), .rxd(rxd),
      .cmd_valid(cmd_valid), .cmd_op(cmd_op), .stale_limit(stale_limit),
      .rd_en(rd_en), .rd_data(rd_data), .rx_empty(rx_empty), .rx_level(rx_level),
      .rx_on(rx_on), .stale_irq(stale_irq), .stale_armed(stale_armed),
      .ovr_err(ovr_err), .frm_err(frm_err), .snap_count(snap_count)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] exp_word(input int first, input int n);
      logic [31:0] w = '0;
      for (int k = 0; k < 4; k++)
         if (k < n) w[8*k +: 8] = sent[first + k];
      return w;
   endfunction

   task automatic bit_out(input logic v);
      rxd = v;
      repeat (OSR) @(negedge clk);
   endtask

   task automatic send_char(input logic [7:0] b, input logic good_stop);
      bit_out(1'b0);
      for (int i = 0; i < 8; i++) bit_out(b[i]);
      bit_out(good_stop);
      rxd = 1'b1;
   endtask

   task automatic send_burst(input int n);
      for (int i = 0; i < n; i++) begin
         logic [7:0] b = 8'($urandom);
         sent[nsent] = b;
         nsent++;
         send_char(b, 1'b1);
      end
   endtask

   task automatic command(input logic [2:0] op);
      @(negedge clk);
      cmd_valid = 1'b1;
      cmd_op    = op;
      @(negedge clk);
      cmd_valid = 1'b0;
      cmd_op    = 3'd0;
   endtask

   task automatic read_check(input string req, input logic [31:0] exp);
      check(req, rd_data, exp);
      rd_en = 1'b1;
      @(negedge clk);
      rd_en = 1'b0;
   endtask

   task automatic wait_stale();
      for (int i = 0; i < 3000; i++) begin
         if (stale_irq) break;
         @(negedge clk);
      end
   endtask

   task automatic finish_burst(input string req);
      int words;
      wait_stale();
      check({req, " R4 stale_irq"}, 32'(stale_irq), 32'd1);
      check({req, " R5 snap_count"}, 32'(snap_count), 32'(nsent));
      words = (nsent + 3) / 4;
      for (int w = 0; w < words; w++) begin
         int nb = (nsent - 4 * w > 4) ? 4 : nsent - 4 * w;
         read_check({req, " R2 word"}, exp_word(4 * w, nb));
      end
      check({req, " R5 valid bytes"}, 32'(4 - (4 * words - int'(snap_count))),
            32'(nsent - 4 * (words - 1)));
      check({req, " R3 empty after reads"}, 32'(rx_empty), 32'd1);
   endtask

   task automatic new_burst();
      command(3'd3);
      command(3'd4);
      nsent = 0;
   endtask

   initial begin
      void'($urandom(32'h5eed_1234));
      nsent = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R12 reset state
      check("R12 empty", 32'(rx_empty), 32'd1);
      check("R12 snap", 32'(snap_count), 32'd0);
      check("R12 flags", {27'd0, rx_on, stale_irq, stale_armed, ovr_err, frm_err}, 32'd0);

      // R11 disabled receiver ignores the line
      send_char(8'h5a, 1'b1);
      repeat (20) @(negedge clk);
      check("R11 disabled empty", 32'(rx_empty), 32'd1);
      command(3'd2);
      check("R11 enabled", 32'(rx_on), 32'd1);
      repeat (800) @(negedge clk);
      check("R11 nothing received", 32'(stale_irq), 32'd0);

      // R1 R2 R3 R4 R5: six-character burst
      new_burst();
      send_burst(6);
      repeat (30) @(negedge clk);
      check("R3 one word queued", 32'(rx_level), 32'd1);
      finish_burst("six");

      // R7 disarmed stale holds the partial word
      command(3'd3);
      check("R7 clear irq", 32'(stale_irq), 32'd0);
      nsent = 0;
      send_burst(2);
      repeat (900) @(negedge clk);
      check("R7 no event while disarmed", 32'(stale_irq), 32'd0);
      check("R7 partial held", 32'(rx_empty), 32'd1);
      command(3'd4);
      finish_burst("rearm R7");

      // R6 short gap keeps the burst open
      new_burst();
      send_burst(1);
      repeat (200) @(negedge clk);
      check("R6 no early stale", 32'(stale_irq), 32'd0);
      send_burst(1);
      finish_burst("gap R6");

      // R1 false start: short low glitch
      new_burst();
      rxd = 1'b0;
      repeat (3) @(negedge clk);
      rxd = 1'b1;
      repeat (900) @(negedge clk);
      check("R1 glitch ignored", 32'(stale_irq), 32'd0);
      check("R1 glitch no data", 32'(rx_empty), 32'd1);

      // R9 framing error
      send_char(8'h3c, 1'b0);
      repeat (40) @(negedge clk);
      check("R9 frm_err set", 32'(frm_err), 32'd1);
      check("R9 frame dropped", 32'(rx_empty), 32'd1);
      nsent = 0;
      send_burst(1);
      finish_burst("after ferr R9");
      check("R9 frm_err sticky", 32'(frm_err), 32'd1);
      command(3'd5);
      check("R9 frm_err cleared", 32'(frm_err), 32'd0);

      // R8 overrun
      new_burst();
      send_burst(16);
      send_char(8'hee, 1'b1);
      repeat (30) @(negedge clk);
      check("R8 ovr_err set", 32'(ovr_err), 32'd1);
      check("R8 fifo full", 32'(rx_level), 32'd4);
      finish_burst("overrun R8");
      check("R8 ovr sticky", 32'(ovr_err), 32'd1);

      // R10 receiver reset
      nsent = 0;
      send_burst(5);
      command(3'd1);
      check("R10 empty", 32'(rx_empty), 32'd1);
      check("R10 snap", 32'(snap_count), 32'd0);
      check("R10 rx_on off", 32'(rx_on), 32'd0);
      check("R10 ovr kept", 32'(ovr_err), 32'd1);
      command(3'd2);
      command(3'd5);
      check("R8 ovr cleared", 32'(ovr_err), 32'd0);
      new_burst();
      send_burst(3);
      finish_burst("post reset R10");

      // random bursts
      for (int r = 0; r < 20; r++) begin
         new_burst();
         send_burst(1 + int'($urandom_range(11)));
         if (r % 4 == 0) repeat (int'($urandom_range(150))) @(negedge clk);
         finish_burst("random R2");
      end

      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      n_tests++;
      n_fail++;
      $display("FAIL watchdog R4: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule